// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key-Code Queue

This block scans a matrix of up to 64 keys and hands the keys it accepts to a processor. It drives a 3-bit row select onto the matrix and reads eight column sense lines back. A key must be seen as the only key down in two complete passes over the matrix before it is accepted. It is then turned into a key code and stored in an eight-entry first-in first-out queue.

The processor reaches the block through a small byte-wide bus. The bus has a chip select, a port select (command/status or data), and active-low read and write strobes. Each clock cycle in which the chip select and a strobe are both low counts as one access. A status byte reports how many codes are queued and whether a code has been lost. The processor can poll that byte, or it can wait for the interrupt request, which stays high while the queue is not empty. Before a data-port read removes a code, the processor must write the fetch command.

Top module: `kbd_scan_ctrl`

## Requirements
- R1: `scanCode` starts at 0 after reset and holds each value for exactly PRESCALE clock cycles (default 64). It then steps to the next value, wrapping from 7 back to 0.
- R2: A key in row r and column c is accepted when it is the only key down during two consecutive complete scan passes. Its code is {2'b00, r[2:0], c[2:0]}.
- R3: The queue holds up to 8 codes and returns them in the order in which they were accepted.
- R4: The status byte has the queued count modulo 8 in bits [2:0], a full flag in bit 3 (set with 8 entries), and the overrun flag in bit 5. All other bits read 0.
- R5: If a key is accepted while 8 codes are queued, the overrun flag is set and that key is discarded. A status read returns the flag and clears it afterwards.
- R6: Writing 0x40 to the command port arms a fetch, and the next data-port read returns the oldest code and removes it. A data-port read while no fetch is armed returns the oldest code and leaves the queue unchanged.
- R7: Two-key lockout: if two or more keys are down together, no key is accepted. Once a key has been accepted, no other key is accepted until a full scan pass sees no key down.
- R8: `irq` is high exactly when the queue holds at least one code.
- R9: After reset the queue is empty, the overrun flag is clear, the status byte reads 0x00 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| cmdSel | input | 1 | 1 selects the command/status port, 0 selects the data port |
| rdN | input | 1 | Read strobe, active low, one access per cycle |
| wrN | input | 1 | Write strobe, active low, one access per cycle |
| dataIn | input | 8 | Write data from the processor |
| dataOut | output | 8 | Status byte or oldest key code, selected by cmdSel |
| scanCode | output | 3 | Encoded row select driven onto the matrix |
| retSense | input | 8 | Column sense lines, 1 means the key in that column of the selected row is down |
| irq | output | 1 | Interrupt request, high while the queue is not empty |

## Verification
The hardest situations to reach are the lockout cases. One is a second key that arrives while an accepted key is still held. The other is the release of that first key while the second key stays down. In both cases the queue must not change. The bench models the matrix as a 64-bit key map indexed by the scan output. It presses and releases keys in overlapping order and waits several full scan passes so that the debounce window has passed before it reads the count. Overrun is reached by queueing nine separate keystrokes without a fetch.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int KEY_W   = 8;
  localparam logic [KEY_W-1:0] CMD_FETCH = 8'h40;

  typedef struct packed {
    logic             push;
    logic [KEY_W-1:0] code;
    logic             pop;
    logic             clrOvr;
  } kbdStrobe_t;
endpackage

// File: rtl/kbd_scan_ctl.sv
module kbd_scan_ctl
  import kbd_pkg::*;
#(
  parameter int PRESCALE = 64,
  parameter int ROWS     = 8,
  parameter int COLS     = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     cmdSel,
  input  logic                     rdN,
  input  logic                     wrN,
  input  logic [KEY_W-1:0]         dataIn,
  input  logic [COLS-1:0]          retSense,
  output logic [$clog2(ROWS)-1:0]  scanRow,
  output kbdStrobe_t               strb
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [PRE_W-1:0] preCnt;
  logic [1:0]       keyCnt, rowHits, sumHits;
  logic [KEY_W-1:0] keyCode, codeNext, candCode;
  logic [COL_W-1:0] colIdx;
  logic             candValid, locked, armed;
  logic             sampleNow, endPass, solo, rdAcc, wrAcc;

  // Saturating hit count (0, 1, 2+) and lowest active column of this row.
  always_comb begin
    rowHits = 2'd0;
    colIdx  = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (retSense[i]) colIdx = COL_W'(i);
    end
    for (int i = 0; i < COLS; i++) begin
      if (retSense[i] && rowHits != 2'd2) rowHits = rowHits + 2'd1;
    end
  end

  always_comb begin
    sampleNow = (preCnt == PRE_LAST);
    endPass   = sampleNow && (scanRow == ROW_LAST);
    sumHits   = ((keyCnt + rowHits) >= 2'd2 || keyCnt == 2'd2 || rowHits == 2'd2)
                ? 2'd2 : keyCnt + rowHits;
    codeNext  = (keyCnt == 2'd0 && rowHits == 2'd1)
                ? KEY_W'({scanRow, colIdx}) : keyCode;
    solo      = (sumHits == 2'd1);
    rdAcc     = !csN && !rdN;
    wrAcc     = !csN && !wrN;
    strb.push   = endPass && solo && candValid && (candCode == codeNext) && !locked;
    strb.code   = codeNext;
    strb.pop    = rdAcc && !cmdSel && armed;
    strb.clrOvr = rdAcc && cmdSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      scanRow   <= '0;
      keyCnt    <= 2'd0;
      keyCode   <= '0;
      candValid <= 1'b0;
      candCode  <= '0;
      locked    <= 1'b0;
      armed     <= 1'b0;
    end else begin
      preCnt <= sampleNow ? '0 : preCnt + 1'b1;
      if (sampleNow) begin
        scanRow <= (scanRow == ROW_LAST) ? '0 : scanRow + 1'b1;
        if (endPass) begin
          keyCnt    <= 2'd0;
          keyCode   <= '0;
          candValid <= solo;
          candCode  <= codeNext;
          if (sumHits == 2'd0)  locked <= 1'b0;
          else if (strb.push)   locked <= 1'b1;
        end else begin
          keyCnt  <= sumHits;
          keyCode <= codeNext;
        end
      end
      if (wrAcc && cmdSel && dataIn == CMD_FETCH) armed <= 1'b1;
      else if (strb.pop)                            armed <= 1'b0;
    end
  end

  // R1: row select only moves at the end of a dwell, and then by one
  p_dwell_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (preCnt != PRE_LAST) |=> $stable(scanRow));
  p_row_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (preCnt == PRE_LAST && scanRow != ROW_LAST) |=> scanRow == $past(scanRow) + 1'b1);
  // R7: an accepted key locks out further acceptance
  p_lock_after_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> locked);
  p_no_push_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !strb.push);
  // R6: a fetch consumes the arming
  p_pop_disarms_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !(wrAcc && cmdSel)) |=> !armed);
endmodule

// File: rtl/kbd_fifo_dp.sv
module kbd_fifo_dp
  import kbd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdSel,
  input  kbdStrobe_t       strb,
  output logic [KEY_W-1:0] dataOut,
  output logic             irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [KEY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             ovr, doPush, doPop, isFull;
  logic [KEY_W-1:0] status;

  always_comb begin
    isFull  = (count == FULL);
    doPush  = strb.push && !isFull;
    doPop   = strb.pop && (count != '0);
    status  = {2'b00, ovr, 1'b0, isFull, count[2:0]};
    dataOut = cmdSel ? status : mem[rdPtr];
    irq     = (count != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovr   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= strb.code;
        wrPtr      <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
      if (strb.push && isFull) ovr <= 1'b1;
      else if (strb.clrOvr)    ovr <= 1'b0;
    end
  end

  // R3: occupancy never exceeds the depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL);
  // R5: a key arriving at a full queue raises overrun and leaves it full
  p_full_overrun_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && isFull && !strb.pop) |=> (ovr && count == FULL));
  // R6: a fetch alone removes exactly one entry
  p_pop_dec_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push && count != '0) |=> count == $past(count) - 1'b1);
  // R8: request follows queue occupancy across pushes
  p_irq_after_push_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.pop) |=> irq);
endmodule

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl
  import kbd_pkg::*;
#(
  parameter int PRESCALE = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       cmdSel,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  output logic [2:0] scanCode,
  input  logic [7:0] retSense,
  output logic       irq
);
  kbdStrobe_t strb;

  kbd_scan_ctl #(.PRESCALE(PRESCALE), .ROWS(8), .COLS(8)) u_ctl (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdSel(cmdSel), .rdN(rdN), .wrN(wrN),
    .dataIn(dataIn), .retSense(retSense), .scanRow(scanCode), .strb(strb)
  );

  kbd_fifo_dp #(.DEPTH(8)) u_dp (
    .clk(clk), .rstN(rstN), .cmdSel(cmdSel), .strb(strb),
    .dataOut(dataOut), .irq(irq)
  );
endmodule

// File: tb/kbd_scan_ctrl_test.sv
`timescale 1ns/1ps
module kbd_scan_ctrl_test;
  localparam int PRESCALE = 64;
  localparam int PASS_CYC = PRESCALE * 8;
  localparam int NKEYS = 6;
  localparam logic [5:0] KEYS [NKEYS] = '{6'o00, 6'o77, 6'o25, 6'o52, 6'o31, 6'o07};

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, cmdSel = 1'b0, rdN = 1'b1, wrN = 1'b1;
  logic [7:0] dataIn = 8'h00, dataOut;
  logic [2:0] scanCode;
  logic [7:0] retSense;
  logic irq;
  logic [63:0] keyMat = '0;
  int nChk = 0, nBad = 0;

  always #2.5 clk = ~clk;
  assign retSense = keyMat[{scanCode, 3'b000} +: 8];

  kbd_scan_ctrl #(.PRESCALE(PRESCALE)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdSel(cmdSel), .rdN(rdN), .wrN(wrN),
    .dataIn(dataIn), .dataOut(dataOut), .scanCode(scanCode),
    .retSense(retSense), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic readPort(input logic sel, output logic [7:0] v);
    @(negedge clk); csN = 1'b0; rdN = 1'b0; cmdSel = sel;
    #1 v = dataOut;
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic writeCmd(input logic [7:0] v);
    @(negedge clk); csN = 1'b0; wrN = 1'b0; cmdSel = 1'b1; dataIn = v;
    @(negedge clk); csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic waitPasses(input int n);
    repeat (n * PASS_CYC) @(negedge clk);
  endtask

  task automatic stroke(input int k);
    keyMat[k] = 1'b1; waitPasses(4);
    keyMat[k] = 1'b0; waitPasses(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [2:0] old;
    int dwell;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: reset state
    #1 check("R9 scan", scanCode, 0);
    check("R9 irq", irq, 0);
    readPort(1'b1, v); check("R9 status", v, 8'h00);
    writeCmd(8'h00);

    // R1: dwell length and stepping
    old = scanCode;
    while (scanCode == old) @(negedge clk);
    old = scanCode; dwell = 0;
    while (scanCode == old) begin @(negedge clk); dwell++; end
    check("R1 dwell", dwell, PRESCALE);
    check("R1 step", scanCode, 3'(old + 1));

    // R2/R3/R8: table of single keystrokes, then fetch in order
    for (int i = 0; i < NKEYS; i++) begin
      stroke(KEYS[i]);
      readPort(1'b1, v); check("R4 count", v, i + 1);
      check("R8 irq", irq, 1);
    end
    readPort(1'b0, v); check("R6 peek", v, {2'b00, KEYS[0]});
    readPort(1'b1, v); check("R6 peek keeps count", v, NKEYS);
    for (int i = 0; i < NKEYS; i++) begin
      writeCmd(8'h40);
      readPort(1'b0, v); check("R2 R3 code order", v, {2'b00, KEYS[i]});
    end
    readPort(1'b1, v); check("R3 drained", v, 8'h00);
    #1 check("R8 irq low", irq, 0);

    // R5: nine keystrokes into eight slots
    for (int i = 0; i < 9; i++) stroke(10 + i);
    readPort(1'b1, v); check("R5 full+overrun", v, 8'h28);
    readPort(1'b1, v); check("R5 overrun cleared", v, 8'h08);
    for (int i = 0; i < 8; i++) begin
      writeCmd(8'h40);
      readPort(1'b0, v); check("R5 kept codes", v, 10 + i);
    end
    readPort(1'b1, v); check("R5 ninth dropped", v, 8'h00);

    // R7: two keys together
    keyMat[3] = 1'b1; keyMat[44] = 1'b1; waitPasses(4);
    readPort(1'b1, v); check("R7 simultaneous", v, 8'h00);
    keyMat = '0; waitPasses(2);
    // R7: second key while first held, then first released
    keyMat[21] = 1'b1; waitPasses(4);
    readPort(1'b1, v); check("R7 first accepted", v, 8'h01);
    keyMat[50] = 1'b1; waitPasses(3);
    keyMat[21] = 1'b0; waitPasses(4);
    readPort(1'b1, v); check("R7 second ignored", v, 8'h01);
    keyMat = '0; waitPasses(2);
    writeCmd(8'h40);
    readPort(1'b0, v); check("R7 held key code", v, 21);
    readPort(1'b1, v); check("R7 empty after", v, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule